// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block runs clause-22 management transactions towards an external PHY. Software loads one 32-bit management word, which carries the whole transaction. The engine then sends a 32-bit preamble of ones and the 32 bits of that word on the management data line, most significant bit first. The management clock is the system clock divided by a factor picked from a short list, so the clock stays within the PHY's limit over a wide range of system clock rates.

The word's field positions follow the bit order on the wire. Bits 31:30 hold the start pattern (01) and bits 29:28 hold the opcode (01 for write, 10 for read). Bits 27:23 hold the PHY address and bits 22:18 the register address. Bits 17:16 hold the turnaround code (10), and bits 15:0 hold the data. On a read, the engine releases the data line from the turnaround onwards and samples 16 bits returned by the PHY. Those bits then replace the data field of the stored word, so reading the word back gives the result. An idle flag tells software when the word may be reused. A port-enable input gates the clock and data-enable pins.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset, and once a frame has ended, idle_o is 1. A word write while idle stores the word and starts a frame, and idle_o is 0 from the next cycle until the frame ends.
- R2: For frame bit i (0..63), mdio_o carries 1 for i < 32 and word bit 63-i otherwise. It changes only while mdc_o is low, so it is stable at each rising edge of mdc_o.
- R3: div_sel_i codes 0,1,2,3,4,5 select a division of 8,16,32,48,64,96 system clocks per MDC period. Codes 6 and 7 select 96. A frame lasts exactly 64 MDC periods.
- R4: The division factor is captured when the frame starts. Changing div_sel_i during a frame has no effect on that frame.
- R5: When word bits 29:28 are 10 (read), mdio_oe_o is 0 from frame bit 46 to the end. mdio_i is sampled at the rising edges of mdc_o in bits 48..63, first bit as the data MSB. At the end of the frame these bits replace word_o[15:0], and word_o[31:16] is unchanged.
- R6: For any other opcode (write), mdio_oe_o is 1 during all 64 frame bits, so the turnaround goes out as 10 from the word. word_o is unchanged by the frame.
- R7: A word write while a frame is running is ignored. word_o and idle_o are unaffected, and the running frame completes normally.
- R8: When port_en_i is 0, mdc_o and mdio_oe_o are held at 0. The frame still runs its full length, and on a read it captures the mdio_i level into the data field.
- R9: While the engine is idle, mdc_o is 0 and mdio_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_sel_i | input | 3 | MDC division select |
| port_en_i | input | 1 | Enables the MDC and MDIO drive pins |
| word_we_i | input | 1 | Write strobe for the management word |
| word_wdata_i | input | 32 | Management word to write |
| word_o | output | 32 | Stored management word, with read data after a read |
| idle_o | output | 1 | High when no frame is running |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Several properties are checked on every cycle. The clock and data enable stay quiet when idle or when the port is disabled. The data line never moves while the clock is high. A frame starts only after a write. The stored word stays frozen while a frame runs. The enable pattern matches the opcode: it releases at bit 46 on reads and drives throughout on writes. Other behaviours are shown only by the bench's scenarios, which use a PHY model. These are the exact bit sequence on the line, the frame length for each divider code, the divider latched at start, and the read data landing in the data field while a mid-frame write is dropped.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS = 32;
  localparam int WORD_W   = 32;
  localparam int DATA_W   = 16;
  localparam int TA_BITS  = 2;
  localparam int OP_MSB   = 29;
  localparam int OP_LSB   = 28;
  localparam int MAX_HALF = 48;
  localparam int HALF_W   = $clog2(MAX_HALF + 1);
  localparam logic [1:0] OP_READ = 2'b10;

  typedef logic [2:0] div_sel_t;

  // half MDC period in system clocks
  function automatic int unsigned half_of(div_sel_t sel);
    case (sel)
      3'd0:    return 4;
      3'd1:    return 8;
      3'd2:    return 16;
      3'd3:    return 24;
      3'd4:    return 32;
      default: return 48;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
  import mdio_pkg::*;
#(
  parameter int CNT_W = HALF_W
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     run_i,
  input  div_sel_t sel_i,
  output logic     tick_o
);
  logic [CNT_W-1:0] cnt_q, half_q;

  assign tick_o = run_i && (cnt_q == half_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= '0;
    end else if (start_i) begin
      cnt_q  <= '0;
      half_q <= CNT_W'(half_of(sel_i));
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int PRE_N  = PRE_BITS,
  parameter int WORD_N = WORD_W,
  parameter int DATA_N = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_N-1:0] word_i,
  input  logic              tick_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mdc_o,
  output logic              sdo_o,
  output logic              drive_o,
  output logic [DATA_N-1:0] rdata_o
);
  localparam int FRAME_N = PRE_N + WORD_N;
  localparam int IDX_W   = $clog2(FRAME_N);
  localparam int REL_IDX = FRAME_N - DATA_N - TA_BITS;
  localparam int CAP_IDX = FRAME_N - DATA_N;

  logic               busy_q, mdc_q, rd_q, drive_q;
  logic [IDX_W-1:0]   idx_q, nxt_idx;
  logic [FRAME_N-1:0] sh_q;
  logic [DATA_N-1:0]  cap_q;
  logic               last_bit;

  assign nxt_idx  = idx_q + 1'b1;
  assign last_bit = (idx_q == IDX_W'(FRAME_N - 1));
  assign done_o   = busy_q & tick_i & mdc_q & last_bit;
  assign busy_o   = busy_q;
  assign mdc_o    = mdc_q;
  assign sdo_o    = sh_q[FRAME_N-1];
  assign drive_o  = busy_q & drive_q;
  assign rdata_o  = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      mdc_q   <= 1'b0;
      rd_q    <= 1'b0;
      drive_q <= 1'b0;
      idx_q   <= '0;
      sh_q    <= '0;
      cap_q   <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      mdc_q   <= 1'b0;
      rd_q    <= (word_i[OP_MSB:OP_LSB] == OP_READ);
      drive_q <= 1'b1;
      idx_q   <= '0;
      sh_q    <= {{PRE_N{1'b1}}, word_i};
      cap_q   <= '0;
    end else if (busy_q && tick_i) begin
      if (!mdc_q) begin
        mdc_q <= 1'b1;
        if (rd_q && idx_q >= IDX_W'(CAP_IDX))
          cap_q <= {cap_q[DATA_N-2:0], mdio_i};
      end else begin
        mdc_q <= 1'b0;
        if (last_bit) begin
          busy_q <= 1'b0;
        end else begin
          idx_q   <= nxt_idx;
          sh_q    <= {sh_q[FRAME_N-2:0], 1'b0};
          drive_q <= !(rd_q && nxt_idx >= IDX_W'(REL_IDX));
        end
      end
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  div_sel_i,
  input  logic        port_en_i,
  input  logic        word_we_i,
  input  logic [31:0] word_wdata_i,
  output logic [31:0] word_o,
  output logic        idle_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic              busy, done, launch, tick, mdc_int, drive;
  logic [WORD_W-1:0] word_q;
  logic [DATA_W-1:0] rdata;

  assign launch = word_we_i & ~busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      word_q <= '0;
    else if (launch)
      word_q <= word_wdata_i;
    else if (done && word_q[OP_MSB:OP_LSB] == OP_READ)
      word_q[DATA_W-1:0] <= rdata;
  end

  mdio_clk_div u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(launch),
    .run_i  (busy),
    .sel_i  (div_sel_i),
    .tick_o (tick)
  );

  mdio_shifter u_shf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(launch),
    .word_i (word_wdata_i),
    .tick_i (tick),
    .mdio_i (mdio_i),
    .busy_o (busy),
    .done_o (done),
    .mdc_o  (mdc_int),
    .sdo_o  (mdio_o),
    .drive_o(drive),
    .rdata_o(rdata)
  );

  assign word_o    = word_q;
  assign idle_o    = ~busy;
  assign mdc_o     = port_en_i & mdc_int;
  assign mdio_oe_o = port_en_i & drive;
endmodule

// File: rtl/mdio_frame_checker.sv
module mdio_frame_checker
  import mdio_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        port_en_i,
  input logic        word_we_i,
  input logic [31:0] word_o,
  input logic        idle_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  localparam int REL_IDX = PRE_BITS + WORD_W - DATA_W - TA_BITS;

  logic       mdc_d;
  logic [6:0] fall_q, fall_now;
  logic       is_rd;

  assign fall_now = fall_q + 7'(mdc_d & ~mdc_o);
  assign is_rd    = (word_o[OP_MSB:OP_LSB] == OP_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdc_d  <= 1'b0;
      fall_q <= '0;
    end else begin
      mdc_d  <= mdc_o;
      fall_q <= idle_o ? '0 : fall_now;
    end
  end

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (!mdc_o && !mdio_oe_o));
  p_start_by_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(idle_o) |-> $past(word_we_i));
  p_data_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_o |-> $stable(mdio_o));
  p_word_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o |=> (idle_o || $stable(word_o)));
  p_upper_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o |=> $stable(word_o[WORD_W-1:DATA_W]));
  p_pins_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |-> (!mdc_o && !mdio_oe_o));
  p_rd_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_en_i && !idle_o && is_rd) |-> (mdio_oe_o == (fall_now < 7'(REL_IDX))));
  p_wr_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_en_i && !idle_o && !is_rd) |-> mdio_oe_o);
endmodule

bind mdio_frame_engine mdio_frame_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .port_en_i(port_en_i),
  .word_we_i(word_we_i),
  .word_o   (word_o),
  .idle_o   (idle_o),
  .mdc_o    (mdc_o),
  .mdio_o   (mdio_o),
  .mdio_oe_o(mdio_oe_o)
);

// File: tb/tb_mdio_frame_engine.sv
module tb_mdio_frame_engine;
  typedef struct packed {
    logic [2:0]  sel;
    logic [31:0] word;
    logic [15:0] ret;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{3'd0, 32'h52821234, 16'h0000, 32'h52821234},
    '{3'd1, 32'h608A0000, 16'hBEEF, 32'h608ABEEF},
    '{3'd2, 32'h5FFEA5A5, 16'hFFFF, 32'h5FFEA5A5},
    '{3'd3, 32'h6F861111, 16'h0F0F, 32'h6F860F0F},
    '{3'd4, 32'h50420000, 16'h1234, 32'h50420000},
    '{3'd5, 32'h61FE0000, 16'h8001, 32'h61FE8001}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  div_sel_i = 3'd0;
  logic        port_en_i = 1'b1;
  logic        word_we_i = 1'b0;
  logic [31:0] word_wdata_i = '0;
  logic [31:0] word_o;
  logic        idle_o, mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  int          rcnt = 0, base = 0;
  logic [63:0] obs_bit, obs_oe;
  logic [15:0] phy_ret = '0;
  int          cyc, pins;

  always #4 clk = ~clk;

  mdio_frame_engine dut (.*, .clk_i(clk));

  // PHY model: records each rising edge, answers reads after turnaround
  always @(posedge mdc_o) begin
    if (rcnt - base < 64) begin
      obs_bit[63-(rcnt-base)] = mdio_o;
      obs_oe[63-(rcnt-base)]  = mdio_oe_o;
    end
    rcnt = rcnt + 1;
  end
  always @(negedge mdc_o) begin
    if (rcnt - base >= 48 && rcnt - base < 64) mdio_i = phy_ret[63-(rcnt-base)];
    else mdio_i = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int div_of(input logic [2:0] s);
    case (s)
      3'd0: return 8;  3'd1: return 16; 3'd2: return 32;
      3'd3: return 48; 3'd4: return 64; default: return 96;
    endcase
  endfunction

  task automatic start_frame(input logic [2:0] s, input logic [31:0] w, input logic [15:0] r);
    phy_ret = r;
    base = rcnt;
    obs_bit = '0;
    obs_oe = '0;
    @(negedge clk);
    div_sel_i = s; word_wdata_i = w; word_we_i = 1'b1;
    @(negedge clk);
    word_we_i = 1'b0;
    cyc = 0;
    pins = 0;
  endtask

  task automatic wait_frame();
    while (!idle_o) begin
      cyc++;
      if (mdc_o || mdio_oe_o) pins++;
      @(negedge clk);
    end
  endtask

  task automatic check_frame(input logic [31:0] w, input string tag);
    logic [63:0] eb, eo;
    eb = {32'hFFFF_FFFF, w};
    eo = (w[29:28] == 2'b10) ? 64'hFFFF_FFFF_FFFC_0000 : '1;
    check((obs_bit & eo) == (eb & eo), {tag, " R2 bits"}, obs_bit & eo, eb & eo);
    check(obs_oe == eo, {tag, (w[29:28] == 2'b10) ? " R5 oe" : " R6 oe"}, obs_oe, eo);
    check(rcnt - base == 64, {tag, " R3 mdc rises"}, 64'(rcnt - base), 64);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 / R1 reset state
    check(idle_o == 1'b1 && word_o == '0, "R1 reset", {31'd0, idle_o, word_o}, {31'd0, 1'b1, 32'd0});
    check(!mdc_o && !mdio_oe_o, "R9 reset pins", {mdc_o, mdio_oe_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(idle_o && !mdc_o && !mdio_oe_o, "R9 idle after reset", {idle_o, mdc_o, mdio_oe_o}, 3'b100);

    for (int k = 0; k < NVEC; k++) begin
      start_frame(VEC[k].sel, VEC[k].word, VEC[k].ret);
      check(!idle_o, "R1 idle low", idle_o, 0);
      wait_frame();
      check(cyc == 64 * div_of(VEC[k].sel), "R3 frame length", cyc, 64 * div_of(VEC[k].sel));
      check_frame(VEC[k].word, "vec");
      check(word_o == VEC[k].exp, "R5 R6 word_o", word_o, VEC[k].exp);
    end

    // R3: codes 6 and 7 select 96
    start_frame(3'd6, 32'h50821111, 16'h0);
    wait_frame();
    check(cyc == 6144, "R3 code 6", cyc, 6144);
    start_frame(3'd7, 32'h50821111, 16'h0);
    wait_frame();
    check(cyc == 6144, "R3 code 7", cyc, 6144);

    // R4: divider change mid-frame ignored
    start_frame(3'd0, 32'h608A0000, 16'h5A5A);
    repeat (40) begin cyc++; @(negedge clk); end
    div_sel_i = 3'd5;
    wait_frame();
    check(cyc == 512, "R4 latched divider", cyc, 512);
    check(word_o == 32'h608A5A5A, "R4 R5 read data", word_o, 32'h608A5A5A);

    // R7: write while busy ignored
    start_frame(3'd0, 32'h52821234, 16'h0);
    repeat (100) begin cyc++; @(negedge clk); end
    word_wdata_i = 32'h6F86FFFF; word_we_i = 1'b1;
    cyc++; @(negedge clk);
    word_we_i = 1'b0;
    check(word_o == 32'h52821234 && !idle_o, "R7 busy write", word_o, 32'h52821234);
    wait_frame();
    check(cyc == 512, "R7 frame length", cyc, 512);
    check_frame(32'h52821234, "busy");
    check(word_o == 32'h52821234, "R7 word kept", word_o, 32'h52821234);

    // R8: port disabled, frame runs, read captures idle-high line
    port_en_i = 1'b0;
    start_frame(3'd0, 32'h608A0000, 16'h1234);
    wait_frame();
    check(pins == 0, "R8 pins gated", pins, 0);
    check(rcnt == base, "R8 no mdc edges", rcnt - base, 0);
    check(cyc == 512, "R8 frame length", cyc, 512);
    check(word_o == 32'h608AFFFF, "R8 captured level", word_o, 32'h608AFFFF);
    port_en_i = 1'b1;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule